// File: doc/BRIEF.md
# PLL Step-Response Measurement Controller

This block measures how a phase-locked loop answers a phase step that the block applies itself. When started, it first averages a run of signed phase-error samples to learn the resting error. It then pulses a step-request line for one cycle and watches the error stream for a programmable number of measurement cycles. From that window it extracts two figures. The crossover time is the number of cycles until the error first swings past the resting value in the direction opposite to the step, and it tracks closed-loop bandwidth. The peak overcorrection is the largest swing seen anywhere in the window, and it tracks jitter peaking.

After the window it averages a final run of samples and reports that as the static phase error, then pulses done. A free-running lock detector watches the same error stream at all times. An optional trace output republishes every sample taken in the window together with its index, so the response can be plotted against time.

The phase detector and its digitizer are outside this block. It consumes one already-quantized two's-complement sample on every clock.

Top module: `pll_step_meter`

## Requirements
- R1: A start accepted in idle first collects 16 baseline samples, whose floor average is the resting error. step_req_o is then high for exactly one cycle: the 17th cycle after the cycle in which start was accepted, counting that cycle as cycle 0.
- R2: Track samples are numbered k = 0, 1, ... starting on the cycle after the step pulse. Define rel = sample − baseline. With step_dir_i = 0 the step is expected to push the error upward, so overcorrection is ov = −rel. With step_dir_i = 1 it is ov = rel. xover_o is k+1 for the first track sample with ov > 0.
- R3: start_i is ignored while busy_o is high; the running measurement and its results are unaffected.
- R4: If no track sample has ov > 0, xover_o reads all ones, overdamped_o is 1 and peak_o is 0. These are also the values after reset.
- R5: peak_o is the largest ov over the whole window, including later ringing lobes, clamped to 2^PE_W − 1.
- R6: lock_o rises after 32 consecutive samples with |pe_i| < lock_thr_i. lock_thr_i is unsigned. It falls on the cycle after any sample with |pe_i| ≥ lock_thr_i. The detector runs in every state.
- R7: static_err_o is the floor average of the 16 samples taken right after the window.
- R8: With trace_en_i high, each track sample appears on trace_pe_o one cycle after it is taken, with trace_idx_o = k and trace_valid_o high. With trace_en_i low, trace_valid_o stays low.
- R9: The track window lasts window_i samples, latched at start. A value of 0 acts as 1.
- R10: done_o is a one-cycle pulse on the cycle after the last of the 16 static-error samples. All results are valid from that cycle until the next accepted start.
- R11: After reset, busy_o, step_req_o, done_o, lock_o and trace_valid_o are 0, and static_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a measurement (taken only when idle) |
| step_dir_i | input | 1 | Expected step polarity: 0 = error rises, 1 = error falls |
| window_i | input | WIN_W | Track window length in samples |
| lock_thr_i | input | PE_W | Lock magnitude threshold, unsigned |
| trace_en_i | input | 1 | Enable per-sample trace output |
| pe_i | input | PE_W | Signed phase-error sample, one per clock |
| step_req_o | output | 1 | One-cycle phase-step request to the loop |
| busy_o | output | 1 | A measurement is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| xover_o | output | WIN_W | Crossover time in cycles |
| overdamped_o | output | 1 | No crossover was seen |
| peak_o | output | PE_W | Peak overcorrection magnitude |
| static_err_o | output | PE_W | Settled signed phase error |
| lock_o | output | 1 | Lock status |
| trace_valid_o | output | 1 | Trace sample valid |
| trace_pe_o | output | PE_W | Traced phase-error sample |
| trace_idx_o | output | WIN_W | Index of the traced sample |

## Verification
The properties assume one meaningful error sample per clock. They also assume the lock threshold does not change between a sample and the following clock. The bench respects both: it changes pe_i and lock_thr_i only at falling edges and never pauses the stream. The bench keeps every synthetic response inside the 12-bit range and chooses baselines so that the alternating baseline pattern never overflows, which is why the floor-average results stay exact. Its responses cover both step polarities, a crossing on the first sample, a second ringing lobe larger than the first, a response that never crosses, and a zero-length window.

// File: rtl/pse_pkg.sv
package pse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BASE,
      ST_STEP,
      ST_TRACK,
      ST_SETTLE,
      ST_DONE
   } pse_state_e;
endpackage

// File: rtl/pse_avg.sv
// Power-of-two sample averager: clear, accumulate, arithmetic shift.
module pse_avg #(
   parameter int PE_W     = 12,
   parameter int AVG_LOG2 = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   clr_i,
   input  logic                   en_i,
   input  logic signed [PE_W-1:0] smp_i,
   output logic signed [PE_W-1:0] avg_o
);
   localparam int SW = PE_W + AVG_LOG2;

   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] sum_sh;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sum_q <= '0;
      else if (clr_i) sum_q <= '0;
      else if (en_i)  sum_q <= sum_q + SW'(smp_i);
   end

   assign sum_sh = sum_q >>> AVG_LOG2;
   assign avg_o  = sum_sh[PE_W-1:0];
endmodule

// File: rtl/pse_lock.sv
// Run-length lock detector on the magnitude of the phase error.
module pse_lock #(
   parameter int PE_W     = 12,
   parameter int LOCK_RUN = 32
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic signed [PE_W-1:0] smp_i,
   input  logic        [PE_W-1:0] thr_i,
   output logic                   lock_o
);
   localparam int RCW = $clog2(LOCK_RUN);

   logic [RCW-1:0]  run_q;
   logic [PE_W-1:0] mag;
   logic            under;

   assign mag   = smp_i[PE_W-1] ? PE_W'(-smp_i) : PE_W'(smp_i);
   assign under = mag < thr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= '0;
         lock_o <= 1'b0;
      end else if (!under) begin
         run_q  <= '0;
         lock_o <= 1'b0;
      end else if (run_q == RCW'(LOCK_RUN - 1)) begin
         lock_o <= 1'b1;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/pse_track.sv
// Crossover timer and peak overcorrection tracker.
module pse_track #(
   parameter int PE_W = 12,
   parameter int CW   = 16
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   clr_i,
   input  logic                   en_i,
   input  logic                   dir_i,
   input  logic signed [PE_W-1:0] smp_i,
   input  logic signed [PE_W-1:0] base_i,
   input  logic        [CW-1:0]   idx_i,
   output logic        [CW-1:0]   xover_o,
   output logic        [PE_W-1:0] peak_o,
   output logic                   over_o
);
   localparam int                     RW     = PE_W + 2;
   localparam logic [PE_W-1:0]        PK_MAX = '1;
   localparam logic signed [RW-1:0]   OV_MAX = RW'(PK_MAX);

   logic signed [RW-1:0] rel;
   logic signed [RW-1:0] ov;
   logic                 ov_hit;
   logic [PE_W-1:0]      ov_mag;
   logic [CW-1:0]        idx_inc;
   logic                 crossed_q;

   assign rel     = RW'(smp_i) - RW'(base_i);
   assign ov      = dir_i ? rel : -rel;
   assign ov_hit  = ov > 0;
   assign ov_mag  = (ov > OV_MAX) ? PK_MAX : ov[PE_W-1:0];
   assign idx_inc = (&idx_i) ? idx_i : idx_i + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crossed_q <= 1'b0;
         xover_o   <= '1;
         peak_o    <= '0;
      end else if (clr_i) begin
         crossed_q <= 1'b0;
         xover_o   <= '1;
         peak_o    <= '0;
      end else if (en_i && ov_hit) begin
         if (!crossed_q) begin
            crossed_q <= 1'b1;
            xover_o   <= idx_inc;
         end
         if (ov_mag > peak_o) peak_o <= ov_mag;
      end
   end

   assign over_o = !crossed_q;
endmodule

// File: rtl/pll_step_meter.sv
module pll_step_meter
   import pse_pkg::*;
#(
   parameter int PE_W     = 12,
   parameter int WIN_W    = 16,
   parameter int AVG_LOG2 = 4,
   parameter int LOCK_RUN = 32,
   parameter bit TRACE_EN = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   input  logic                   step_dir_i,
   input  logic [WIN_W-1:0]       window_i,
   input  logic [PE_W-1:0]        lock_thr_i,
   input  logic                   trace_en_i,
   input  logic signed [PE_W-1:0] pe_i,
   output logic                   step_req_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [WIN_W-1:0]       xover_o,
   output logic                   overdamped_o,
   output logic [PE_W-1:0]        peak_o,
   output logic signed [PE_W-1:0] static_err_o,
   output logic                   lock_o,
   output logic                   trace_valid_o,
   output logic signed [PE_W-1:0] trace_pe_o,
   output logic [WIN_W-1:0]       trace_idx_o
);
   localparam int AVG_N = 1 << AVG_LOG2;
   localparam int EW    = WIN_W + 1;

   if (PE_W < 4 || WIN_W < 8 || AVG_LOG2 < 1 || LOCK_RUN < 2 || WIN_W <= AVG_LOG2)
   begin : g_bad_params
      $error("pll_step_meter: parameter out of range");
   end

   pse_state_e             state_q;
   logic [WIN_W-1:0]       cnt_q;
   logic [WIN_W-1:0]       win_q;
   logic                   dir_q;
   logic                   take;
   logic                   avg_last;
   logic                   trk_last;
   logic signed [PE_W-1:0] base_avg;

   assign take     = (state_q == ST_IDLE) && start_i;
   assign avg_last = cnt_q == WIN_W'(AVG_N - 1);
   assign trk_last = (EW'(cnt_q) + EW'(1)) >= EW'(win_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         win_q   <= '0;
         dir_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take) begin
               state_q <= ST_BASE;
               cnt_q   <= '0;
               win_q   <= window_i;
               dir_q   <= step_dir_i;
            end
            ST_BASE: begin
               cnt_q <= cnt_q + 1'b1;
               if (avg_last) state_q <= ST_STEP;
            end
            ST_STEP: begin
               cnt_q   <= '0;
               state_q <= ST_TRACK;
            end
            ST_TRACK: begin
               cnt_q <= cnt_q + 1'b1;
               if (trk_last) begin
                  cnt_q   <= '0;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               cnt_q <= cnt_q + 1'b1;
               if (avg_last) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = state_q != ST_IDLE;
   assign step_req_o = state_q == ST_STEP;
   assign done_o     = state_q == ST_DONE;

   pse_avg #(.PE_W(PE_W), .AVG_LOG2(AVG_LOG2)) base_avg_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (take),
      .en_i  (state_q == ST_BASE),
      .smp_i (pe_i),
      .avg_o (base_avg)
   );

   pse_avg #(.PE_W(PE_W), .AVG_LOG2(AVG_LOG2)) settle_avg_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (take),
      .en_i  (state_q == ST_SETTLE),
      .smp_i (pe_i),
      .avg_o (static_err_o)
   );

   pse_track #(.PE_W(PE_W), .CW(WIN_W)) track_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (take),
      .en_i   (state_q == ST_TRACK),
      .dir_i  (dir_q),
      .smp_i  (pe_i),
      .base_i (base_avg),
      .idx_i  (cnt_q),
      .xover_o(xover_o),
      .peak_o (peak_o),
      .over_o (overdamped_o)
   );

   pse_lock #(.PE_W(PE_W), .LOCK_RUN(LOCK_RUN)) lock_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (pe_i),
      .thr_i (lock_thr_i),
      .lock_o(lock_o)
   );

   if (TRACE_EN) begin : g_trace
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            trace_valid_o <= 1'b0;
            trace_pe_o    <= '0;
            trace_idx_o   <= '0;
         end else begin
            trace_valid_o <= trace_en_i && (state_q == ST_TRACK);
            trace_pe_o    <= pe_i;
            trace_idx_o   <= cnt_q;
         end
      end
   end else begin : g_no_trace
      logic unused_trace;
      assign unused_trace  = trace_en_i;
      assign trace_valid_o = 1'b0;
      assign trace_pe_o    = '0;
      assign trace_idx_o   = '0;
   end
endmodule

// File: rtl/pll_step_meter_chk.sv
module pll_step_meter_chk #(
   parameter int PE_W  = 12,
   parameter int WIN_W = 16
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic signed [PE_W-1:0] pe_i,
   input logic [PE_W-1:0]        lock_thr_i,
   input logic                   step_req_o,
   input logic                   busy_o,
   input logic                   done_o,
   input logic [WIN_W-1:0]       xover_o,
   input logic                   overdamped_o,
   input logic [PE_W-1:0]        peak_o,
   input logic                   lock_o,
   input logic                   trace_valid_o
);
   logic [PE_W-1:0] mag;
   assign mag = pe_i[PE_W-1] ? PE_W'(-pe_i) : PE_W'(pe_i);

   a_r1_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_req_o |=> !step_req_o);

   a_r1_step_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_req_o |-> busy_o);

   a_r4_no_cross_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overdamped_o |-> (xover_o == '1));

   a_r4_no_cross_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overdamped_o |-> (peak_o == '0));

   a_r6_lock_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mag >= lock_thr_i) |=> !lock_o);

   a_r8_trace_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trace_valid_o |-> busy_o);

   a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   a_r10_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);
endmodule

bind pll_step_meter pll_step_meter_chk #(.PE_W(PE_W), .WIN_W(WIN_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pe_i         (pe_i),
   .lock_thr_i   (lock_thr_i),
   .step_req_o   (step_req_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .xover_o      (xover_o),
   .overdamped_o (overdamped_o),
   .peak_o       (peak_o),
   .lock_o       (lock_o),
   .trace_valid_o(trace_valid_o)
);

// File: tb/pll_step_meter_tb_top.sv
module pll_step_meter_tb_top;
   localparam int PE_W  = 12;
   localparam int WIN_W = 16;

   typedef struct packed {
      bit dir;
      int base;
      int amp;
      int tc;
      int o1;
      int o2;
      int win;
      int soff;
      bit tren;
   } vec_t;

   // dir, base, amp, tc, o1, o2, win, soff, trace
   localparam vec_t VECS [7] = '{
      '{1'b0,   10, 200,  5,   60,  0, 40,     3, 1'b1},
      '{1'b1, -100, 300, 12,  150,  0, 40,    -2, 1'b0},
      '{1'b0,    0, 100, 50,   30,  0, 30,     0, 1'b0},
      '{1'b1,    5,  50,  0,   20,  0, 10,     1, 1'b0},
      '{1'b0, 2046,   0,  2, 4094,  0, 20, -4000, 1'b1},
      '{1'b1, -300, 120,  3,   30, 70, 40,     5, 1'b0},
      '{1'b0,    7,   0,  0,    9,  0,  0,    -7, 1'b0}
   };

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start = 1'b0;
   logic                   dir = 1'b0;
   logic [WIN_W-1:0]       window = '0;
   logic [PE_W-1:0]        thr = 12'd20;
   logic                   tren = 1'b0;
   logic signed [PE_W-1:0] pe = '0;
   logic                   step_req, busy, done, odamp, lock, tvalid;
   logic [WIN_W-1:0]       xover, tidx;
   logic [PE_W-1:0]        peak;
   logic signed [PE_W-1:0] serr, tpe;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   pll_step_meter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_dir_i(dir),
      .window_i(window), .lock_thr_i(thr), .trace_en_i(tren), .pe_i(pe),
      .step_req_o(step_req), .busy_o(busy), .done_o(done), .xover_o(xover),
      .overdamped_o(odamp), .peak_o(peak), .static_err_o(serr), .lock_o(lock),
      .trace_valid_o(tvalid), .trace_pe_o(tpe), .trace_idx_o(tidx)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clip(input int x);
      if (x > 2047)  return 2047;
      if (x < -2048) return -2048;
      return x;
   endfunction

   // synthetic loop response for track sample k
   function automatic int pe_at(input vec_t v, input int k);
      int sg;
      sg = v.dir ? -1 : 1;
      if (k < v.tc)                          return clip(v.base + sg * v.amp);
      if (k < v.tc + 4)                      return clip(v.base - sg * v.o1);
      if (k >= v.tc + 8 && k < v.tc + 11)    return clip(v.base - sg * v.o2);
      return v.base;
   endfunction

   task automatic run_vec(input vec_t v, input int vi);
      int eff, xo, pk, i, prev, tbad;
      eff = (v.win < 1) ? 1 : v.win;
      xo = -1; pk = 0;
      for (int k = 0; k < eff; k++) begin
         int ov;
         ov = v.dir ? (pe_at(v, k) - v.base) : (v.base - pe_at(v, k));
         if (ov > 0) begin
            if (xo < 0) xo = k + 1;
            if (ov > pk) pk = (ov > 4095) ? 4095 : ov;
         end
      end
      @(negedge clk);
      start = 1'b1; dir = v.dir; window = WIN_W'(v.win); tren = v.tren; pe = PE_W'(v.base);
      @(negedge clk);
      start = 1'b0;
      i = 0;
      while (!step_req && i < 40) begin
         pe = PE_W'(v.base + (i & 1));
         i++;
         @(negedge clk);
      end
      chk(i == 16, "R1", "step pulse delay", i, 16);
      pe = PE_W'(v.base);
      @(negedge clk);
      chk(!step_req, "R1", "step pulse width", step_req, 0);
      tbad = 0; prev = 0;
      for (int k = 0; k <= eff; k++) begin
         if (k > 0) begin
            if (v.tren && (!tvalid || tidx != WIN_W'(k - 1) || tpe != PE_W'(prev))) tbad++;
            if (!v.tren && tvalid) tbad++;
         end
         if (k == eff) break;
         prev = pe_at(v, k);
         pe = PE_W'(prev);
         start = (vi == 1 && k == 3);  // R3: start during a run
         @(negedge clk);
      end
      start = 1'b0;
      chk(tbad == 0, "R8", "trace mismatches", tbad, 0);
      for (int s = 0; s < 16; s++) begin
         chk(!done || s > 0, "R10", "done early", done, 0);
         pe = PE_W'(v.base + v.soff);
         @(negedge clk);
      end
      chk(done, "R10", "done after settle", done, 1);
      chk(xover == WIN_W'((xo < 0) ? 65535 : xo), (xo < 0) ? "R4" : "R2",
          "crossover", xover, (xo < 0) ? 65535 : xo);
      chk(odamp == (xo < 0), "R4", "overdamped flag", odamp, (xo < 0));
      chk(peak == PE_W'(pk), (v.o2 > v.o1) ? "R5" : "R5", "peak", peak, pk);
      chk(serr == PE_W'(v.base + v.soff), "R7", "static error", serr, v.base + v.soff);
      if (vi == 1) chk(xover == WIN_W'(xo), "R3", "start while busy ignored", xover, xo);
      if (vi == 6) chk(xover == 16'd1, "R9", "zero window acts as one", xover, 1);
      @(negedge clk);
      chk(!done && !busy, "R10", "done single cycle", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog expired: actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !step_req && !done, "R11", "control idle in reset", {busy, step_req, done}, 0);
      chk(!lock && !tvalid && serr == 0, "R11", "status idle in reset", {lock, tvalid}, 0);
      chk(xover == '1 && odamp && peak == 0, "R4", "reset results", xover, 65535);
      rst_n = 1'b1;
      @(negedge clk);
      for (int vi = 0; vi < 7; vi++) run_vec(VECS[vi], vi);

      // R6 lock detector
      thr = 12'd20;
      @(negedge clk); pe = 12'sd100;
      for (int j = 0; j <= 32; j++) begin
         @(negedge clk);
         if (j == 1)  chk(!lock, "R6", "lock low after big sample", lock, 0);
         if (j == 31) chk(!lock, "R6", "lock after 31 small", lock, 0);
         if (j == 32) chk(lock, "R6", "lock after 32 small", lock, 1);
         pe = 12'sd5;
      end
      pe = 12'sd20;
      @(negedge clk);
      chk(!lock, "R6", "lock drops at threshold", lock, 0);
      for (int j = 0; j < 32; j++) begin
         pe = -12'sd19;
         @(negedge clk);
      end
      chk(lock, "R6", "lock with negative small error", lock, 1);
      pe = -12'sd2048;
      @(negedge clk);
      chk(!lock, "R6", "lock drops on most negative", lock, 0);

      // R11 reset in the middle of a run
      pe = '0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !step_req, "R11", "mid-run reset clears run", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule